// File: doc/BRIEF.md
# Four-Phase Handshake Byte Link

This block carries bytes in one direction between two clock domains that share no phase or frequency relationship. In the sending domain, a counter offers its current value as the payload of one transfer. In the receiving domain, a capture stage takes the byte and hands it to local logic as a one-cycle strobe. The two sides share only three things: a request net, an acknowledge net and a parallel data bus. Each side passes the handshake net it does not own through a two-flop synchroniser before acting on it.

Each transfer is a full four-phase exchange, in this order: request goes high, acknowledge goes high, request goes low, acknowledge goes low. The sender moves its counter forward only once the whole exchange has finished, and only while request is low. The bus is therefore never changing when the receiver samples it.

The sender FSM has three states:
- `TX_SETUP`: payload on the bus, request low.
- `TX_ASK`: request high, waiting for the synchronised acknowledge to go high.
- `TX_DROP`: request low, waiting for the synchronised acknowledge to go low.

Its transitions are:
- `SETUP→ASK`: unconditional, one cycle.
- `ASK→DROP`: acknowledge seen high.
- `DROP→SETUP`: acknowledge seen low; the counter increments.

The receiver FSM has two states:
- `RX_IDLE`: acknowledge low.
- `RX_HOLD`: acknowledge high.

Its transitions are:
- `IDLE→HOLD`: synchronised request seen high; the byte is captured and the strobe is raised.
- `HOLD→IDLE`: synchronised request seen low.

Top module: `byte_handshake_link`

## Requirements
- R1: While both resets are asserted, `hs_req` and `hs_ack` are 0, `hs_data` is 0 and `rx_valid` is 0.
- R2: `hs_data` holds a value for at least one sender cycle with `hs_req` low before `hs_req` rises. `hs_data` does not change while `hs_req` is high, or in the sender cycle after it falls.
- R3: `hs_ack` rises in the same receiver cycle as `rx_valid`. `hs_ack` falls only after `hs_req` has been low.
- R4: `hs_req` falls only after `hs_ack` has been high. `hs_req` rises only while `hs_ack` has been low.
- R5: `hs_data` changes only by +1 per completed handshake. It wraps from 255 to 0.
- R6: `rx_valid` is high for exactly one receiver cycle per transfer. `rx_data` holds the captured byte and changes only with that strobe.
- R7: Across unrelated clock frequencies, the received bytes are 0, 1, 2, …, 255, 0, … with no byte lost or repeated.
- R8: `hs_ack` rises 2 to 3 receiver clock edges after `hs_req` is first observed high in the receiver domain. This is set by the two-flop synchroniser plus the FSM register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Sender domain clock |
| tx_rst_n | input | 1 | Sender domain reset, active low, asynchronous |
| rx_clk | input | 1 | Receiver domain clock |
| rx_rst_n | input | 1 | Receiver domain reset, active low, asynchronous |
| hs_req | output | 1 | Request net, driven from the sender domain |
| hs_ack | output | 1 | Acknowledge net, driven from the receiver domain |
| hs_data | output | 8 | Parallel payload bus, driven from the sender domain |
| rx_valid | output | 1 | One-cycle strobe: a new byte is on `rx_data` |
| rx_data | output | 8 | Byte captured by the receiver |

## Verification
The acknowledge is due 2 or 3 receiver edges after the request is first seen high in the receiver domain. The strobe and the captured byte appear in the same receiver cycle as the acknowledge. The sender's counter moves in the sender cycle after the synchronised acknowledge falls.

All outputs are sampled on the falling edge of the clock of the domain that drives them. Any comparison across domains uses the value observed at the previous sample of the same domain, so a fast opposite clock cannot make a check race the handshake. The sweep runs more than two full wraps of the counter, first with a receiver slower than the sender and then, after a fresh reset, with one about three times faster.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    // Sender handshake phases
    typedef enum logic [1:0] {
        TX_SETUP = 2'b00,
        TX_ASK   = 2'b01,
        TX_DROP  = 2'b10
    } tx_state_e;

    // Receiver handshake phases
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HOLD = 1'b1
    } rx_state_e;

endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $fatal(1, "hsl_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hsl_producer.sv
module hsl_producer
    import hsl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_async,
    output logic              req_out,
    output logic [DATA_W-1:0] data_out
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic [DATA_W-1:0] count_q;
    logic              ack_s;
    logic              advance;

    hsl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_async),
        .q     (ack_s)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            TX_SETUP: state_d = TX_ASK;
            TX_ASK: begin
                if (ack_s) state_d = TX_DROP;
            end
            TX_DROP: begin
                if (!ack_s) begin
                    state_d = TX_SETUP;
                    advance = 1'b1;
                end
            end
            default: state_d = TX_SETUP;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_SETUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Payload counter, only moves with request low and acknowledge released
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + STEP;
        end
    end

    // Outputs decoded from the state register bit
    always_comb begin
        req_out  = (state_q == TX_ASK);
        data_out = count_q;
    end

endmodule

// File: rtl/hsl_consumer.sv
module hsl_consumer
    import hsl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [DATA_W-1:0] data_async,
    output logic              ack_out,
    output logic              valid_out,
    output logic [DATA_W-1:0] data_out
);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic              req_s;
    logic              take;
    logic              valid_q;
    logic [DATA_W-1:0] byte_q;

    hsl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_s)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (req_s) begin
                    state_d = RX_HOLD;
                    take    = 1'b1;
                end
            end
            RX_HOLD: begin
                if (!req_s) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture and strobe, registered alongside the state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            valid_q <= take;
            if (take) byte_q <= data_async;
        end
    end

    // Outputs
    always_comb begin
        ack_out   = (state_q == RX_HOLD);
        valid_out = valid_q;
        data_out  = byte_q;
    end

endmodule

// File: rtl/byte_handshake_link.sv
module byte_handshake_link #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    output logic              hs_req,
    output logic              hs_ack,
    output logic [DATA_W-1:0] hs_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);

    hsl_producer #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tx (
        .clk       (tx_clk),
        .rst_n     (tx_rst_n),
        .ack_async (hs_ack),
        .req_out   (hs_req),
        .data_out  (hs_data)
    );

    hsl_consumer #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk        (rx_clk),
        .rst_n      (rx_rst_n),
        .req_async  (hs_req),
        .data_async (hs_data),
        .ack_out    (hs_ack),
        .valid_out  (rx_valid),
        .data_out   (rx_data)
    );

endmodule

// File: rtl/hsl_checker.sv
module hsl_checker #(
    parameter int DATA_W = 8
) (
    input logic              tx_clk,
    input logic              tx_rst_n,
    input logic              rx_clk,
    input logic              rx_rst_n,
    input logic              hs_req,
    input logic              hs_ack,
    input logic [DATA_W-1:0] hs_data,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data
);

    AST_DATA_HELD: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $past(hs_req) |-> $stable(hs_data)); // R2
    AST_DATA_BEFORE_REQ: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $rose(hs_req) |-> $stable(hs_data)); // R2
    AST_COUNT_STEP: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        !$stable(hs_data) |-> (hs_data == DATA_W'($past(hs_data) + 1'b1))); // R5
    AST_REQ_DROP_AFTER_ACK: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $fell(hs_req) |-> $past(hs_ack)); // R4
    AST_REQ_RISE_ACK_LOW: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $rose(hs_req) |-> !$past(hs_ack)); // R4
    AST_VALID_PULSE: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_RXDATA_HELD: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        !rx_valid |-> $stable(rx_data)); // R6
    AST_ACK_WITH_VALID: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        $rose(hs_ack) |-> rx_valid); // R3
    AST_ACK_DROP_REQ_LOW: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        $fell(hs_ack) |-> !$past(hs_req)); // R3

endmodule

bind byte_handshake_link hsl_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/byte_handshake_link_tb.sv
`timescale 1ns/1ps
module byte_handshake_link_tb;

    logic       tx_clk = 1'b0;
    logic       rx_clk = 1'b0;
    logic       tx_rst_n = 1'b0;
    logic       rx_rst_n = 1'b0;
    logic       hs_req, hs_ack, rx_valid;
    logic [7:0] hs_data, rx_data;

    realtime rx_half = 13.3ns;
    int  checks = 0;
    int  failures = 0;
    bit  mon_en = 1'b0;
    int  rcv_cnt = 0;
    int  wraps = 0;
    int  exp_byte = 0;

    always #10 tx_clk = ~tx_clk;
    always #(rx_half) rx_clk = ~rx_clk;

    byte_handshake_link u_dut (
        .tx_clk   (tx_clk),
        .tx_rst_n (tx_rst_n),
        .rx_clk   (rx_clk),
        .rx_rst_n (rx_rst_n),
        .hs_req   (hs_req),
        .hs_ack   (hs_ack),
        .hs_data  (hs_data),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Sender-domain monitor
    logic       t_req_p = 1'b0, t_ack_p = 1'b0;
    logic [7:0] t_data_p = 8'd0;
    always @(negedge tx_clk) begin
        if (mon_en) begin
            if (t_req_p && hs_data != t_data_p)
                chk(1'b0, "R2 data moved with request high", hs_data, t_data_p);
            if (hs_data != t_data_p) begin
                chk(hs_data == 8'(t_data_p + 8'd1), "R5 counter step", hs_data, 8'(t_data_p + 8'd1));
                chk(!hs_req, "R2 data changed with request high", hs_req, 0);
            end
            if (!t_req_p && hs_req) begin
                chk(!t_ack_p, "R4 request rose with ack high", t_ack_p, 0);
                chk(hs_data == t_data_p, "R2 data settled before request", hs_data, t_data_p);
            end
            if (t_req_p && !hs_req)
                chk(t_ack_p, "R4 request fell without ack", t_ack_p, 1);
        end
        t_req_p  = hs_req;
        t_ack_p  = hs_ack;
        t_data_p = hs_data;
    end

    // Receiver-domain monitor
    logic r_req_p = 1'b0, r_ack_p = 1'b0, r_val_p = 1'b0;
    bit   r_wait = 1'b0;
    int   r_lat = 0;
    always @(negedge rx_clk) begin
        if (mon_en) begin
            if (rx_valid) begin
                chk(int'(rx_data) == exp_byte, "R7 byte sequence", rx_data, exp_byte);
                if (rx_data == 8'd0 && rcv_cnt > 0) wraps++;
                exp_byte = (exp_byte + 1) % 256;
                rcv_cnt++;
                chk(!r_val_p, "R6 strobe longer than one cycle", r_val_p, 0);
            end
            if (!r_ack_p && hs_ack)
                chk(rx_valid, "R3 ack rose without strobe", rx_valid, 1);
            if (r_ack_p && !hs_ack)
                chk(!r_req_p, "R3 ack fell while request high", r_req_p, 0);
            if (r_wait) begin
                if (hs_ack) begin
                    chk(r_lat == 2 || r_lat == 3, "R8 ack latency", r_lat, 3);
                    r_wait = 1'b0;
                end else begin
                    r_lat++;
                end
            end else if (hs_req && !hs_ack) begin
                r_wait = 1'b1;
                r_lat  = 1;
            end
        end
        r_req_p = hs_req;
        r_ack_p = hs_ack;
        r_val_p = rx_valid;
    end

    task automatic reset_and_check();
        mon_en   = 1'b0;
        tx_rst_n = 1'b0;
        rx_rst_n = 1'b0;
        repeat (4) @(negedge tx_clk);
        chk(!hs_req, "R1 reset request", hs_req, 0);
        chk(!hs_ack, "R1 reset ack", hs_ack, 0);
        chk(hs_data == 8'd0, "R1 reset data", hs_data, 0);
        chk(!rx_valid, "R1 reset strobe", rx_valid, 0);
        exp_byte = 0;
        rcv_cnt  = 0;
        wraps    = 0;
        mon_en   = 1'b1;
        @(negedge rx_clk);
        rx_rst_n = 1'b1;
        @(negedge tx_clk);
        tx_rst_n = 1'b1;
    endtask

    task automatic run_phase(input int n);
        wait (rcv_cnt >= n);
        repeat (4) @(negedge tx_clk);
        chk(wraps >= 2, "R5 counter wrapped to zero", wraps, 2);
        chk(rcv_cnt >= n, "R7 transfer count", rcv_cnt, n);
    endtask

    initial begin
        // Receiver slower than sender
        rx_half = 13.3ns;
        reset_and_check();
        run_phase(600);
        // Receiver about three times faster than sender
        rx_half = 3.7ns;
        reset_and_check();
        run_phase(600);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tx_clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", rcv_cnt, 600);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule